// File: doc/BRIEF.md
# Repeating BCD Alarm Comparator

This block holds four alarm bytes (second, minute, hour and day of month) and compares them with a running BCD time that a separate timekeeping block supplies. When the enabled fields agree on a one-second tick, the block raises a single-cycle interrupt pulse.

The top bit of every alarm byte is a "don't care" flag for that field. The pattern of these flags across the four fields sets how often the alarm repeats:

- Nothing is flagged: the alarm fires once a month.
- The date is flagged: it fires daily.
- The date and the hour are flagged: it fires hourly.
- The date, the hour and the minute are flagged: it fires once a minute.
- Any other pattern: it fires on every tick.

Software loads the alarm bytes through a byte-wide write port. A write whose BCD value is out of range for its field is dropped.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset all four alarm bytes are 0x00 and `irq` is low; with those bytes a tick at time 00:00:00 on date 0x00 raises `irq`.
- R2: A write with `wr_en` high stores the whole byte, mask bit included, into the field picked by `wr_sel` (0 second, 1 minute, 2 hour, 3 date), provided the value is accepted.
- R3: A second or minute write is accepted only if bits [6:0] form legal BCD (low digit at most 9) with value 0 to 59.
- R4: An hour write is accepted only if bits [5:0] form legal BCD with value 0 to 23.
- R5: A date write is accepted only if bits [5:0] form legal BCD with value 1 to 31.
- R6: A rejected write leaves every alarm byte unchanged.
- R7: With no mask bit set, a tick raises `irq` only when second, minute, hour and date all match.
- R8: With only the date mask set, a tick raises `irq` when second, minute and hour match.
- R9: With only the date and hour masks set, a tick raises `irq` when second and minute match.
- R10: With the date, hour and minute masks set and the second mask clear, a tick raises `irq` when the second matches.
- R11: Every other mask pattern raises `irq` on every tick.
- R12: Fields compare second and minute on bits [6:0] and hour and date on bits [5:0]. Nothing fires without a tick. `irq` is high for exactly the one cycle after a matching tick cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Alarm byte write strobe |
| wr_sel | input | 2 | Field select: 0 sec, 1 min, 2 hour, 3 date |
| wr_data | input | 8 | Byte to write; bit 7 is the field mask |
| tick | input | 1 | One-cycle pulse, once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| irq | output | 1 | Single-cycle alarm pulse |

## Verification
A write takes effect at the clock edge where it is sampled, so a tick in the next cycle already sees the new byte. The interrupt for a tick sampled at one edge becomes visible just after that edge and drops at the following edge.

The bench drives inputs on falling edges and samples `irq` on the falling edge one cycle after the tick. Its reference model advances on every rising edge, and `irq` is compared with the model on every falling edge. Rejected writes are verified through the alarm behaviour they would have altered.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

  localparam int BYTE_W   = 8;
  localparam int N_FIELDS = 4;
  localparam int SEL_W    = $clog2(N_FIELDS);

  localparam logic [SEL_W-1:0] SEL_SEC  = 2'd0;
  localparam logic [SEL_W-1:0] SEL_MIN  = 2'd1;
  localparam logic [SEL_W-1:0] SEL_HOUR = 2'd2;
  localparam logic [SEL_W-1:0] SEL_DATE = 2'd3;

  typedef enum logic [2:0] {
    RPT_MONTH  = 3'd0,
    RPT_DAY    = 3'd1,
    RPT_HOUR   = 3'd2,
    RPT_MINUTE = 3'd3,
    RPT_SECOND = 3'd4
  } rpt_e;

  typedef logic [N_FIELDS-1:0][BYTE_W-1:0] field_vec_t;

  // bits of a field that take part in range checks and compares
  function automatic logic [BYTE_W-1:0] value_bits(input logic [SEL_W-1:0] sel);
    if (sel == SEL_SEC || sel == SEL_MIN) return 8'h7F;
    return 8'h3F;
  endfunction

  function automatic int unsigned bcd_to_int(input logic [BYTE_W-1:0] b);
    return 32'(b[7:4]) * 10 + 32'(b[3:0]);
  endfunction

  function automatic logic field_ok(input logic [SEL_W-1:0] sel,
                                    input logic [BYTE_W-1:0] data);
    logic [BYTE_W-1:0] v;
    int unsigned       n;
    v = data & value_bits(sel);
    n = bcd_to_int(v);
    if (v[3:0] > 4'd9) return 1'b0;
    case (sel)
      SEL_SEC, SEL_MIN: return n <= 59;
      SEL_HOUR:         return n <= 23;
      default:          return (n >= 1) && (n <= 31);
    endcase
  endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
  import bcd_alarm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wr_data,
  output field_vec_t        regs_q,
  output logic              wr_accept
);

  assign wr_accept = wr_en && field_ok(wr_sel, wr_data);

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_field
    always_ff @(posedge clk) begin
      if (!rst_n)
        regs_q[i] <= '0;
      else if (wr_accept && wr_sel == SEL_W'(i))
        regs_q[i] <= wr_data;
    end

    // R2: an accepted write to this field lands as the full byte
    assert_accept_store_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_accept && wr_sel == SEL_W'(i)) |=> (regs_q[i] == $past(wr_data)));
  end

  // R6: a rejected write leaves every byte where it was
  assert_reject_hold_R6 : assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_accept) |=> $stable(regs_q));

endmodule

// File: rtl/alarm_match.sv
module alarm_match
  import bcd_alarm_pkg::*;
(
  input  field_vec_t        regs_q,
  input  field_vec_t        now,
  output rpt_e              rpt,
  output logic [N_FIELDS-1:0] field_eq,
  output logic              hit
);

  for (genvar i = 0; i < N_FIELDS; i++) begin : g_cmp
    localparam logic [BYTE_W-1:0] VMASK = value_bits(SEL_W'(i));
    assign field_eq[i] = (regs_q[i] & VMASK) == (now[i] & VMASK);
  end

  logic [N_FIELDS-1:0] dont_care;
  for (genvar i = 0; i < N_FIELDS; i++) begin : g_mask
    assign dont_care[i] = regs_q[i][BYTE_W-1];
  end

  // cascade of masks ordered date, hour, minute, second
  always_comb begin
    case ({dont_care[SEL_DATE], dont_care[SEL_HOUR], dont_care[SEL_MIN], dont_care[SEL_SEC]})
      4'b0000: rpt = RPT_MONTH;
      4'b1000: rpt = RPT_DAY;
      4'b1100: rpt = RPT_HOUR;
      4'b1110: rpt = RPT_MINUTE;
      default: rpt = RPT_SECOND;
    endcase
  end

  always_comb begin
    case (rpt)
      RPT_MONTH:  hit = &field_eq;
      RPT_DAY:    hit = field_eq[SEL_SEC] & field_eq[SEL_MIN] & field_eq[SEL_HOUR];
      RPT_HOUR:   hit = field_eq[SEL_SEC] & field_eq[SEL_MIN];
      RPT_MINUTE: hit = field_eq[SEL_SEC];
      default:    hit = 1'b1;
    endcase
  end

endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp
  import bcd_alarm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [7:0] wr_data,
  input  logic       tick,
  input  logic [7:0] cur_sec,
  input  logic [7:0] cur_min,
  input  logic [7:0] cur_hour,
  input  logic [7:0] cur_date,
  output logic       irq
);

  field_vec_t          regs_q;
  field_vec_t          now;
  logic                wr_accept;
  rpt_e                rpt;
  logic [N_FIELDS-1:0] field_eq;
  logic                hit;
  logic                fire;

  assign now[SEL_SEC]  = cur_sec;
  assign now[SEL_MIN]  = cur_min;
  assign now[SEL_HOUR] = cur_hour;
  assign now[SEL_DATE] = cur_date;

  alarm_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .regs_q    (regs_q),
    .wr_accept (wr_accept)
  );

  alarm_match u_match (
    .regs_q   (regs_q),
    .now      (now),
    .rpt      (rpt),
    .field_eq (field_eq),
    .hit      (hit)
  );

  assign fire = tick & hit;

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= fire;
  end

  // R12: a pulse only ever follows a tick cycle
  assert_tick_gate_R12 : assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(tick));

  // R11: the every-tick pattern never misses a tick
  assert_every_tick_R11 : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rpt == RPT_SECOND) |=> irq);

  // R7: monthly repeat needs every field to agree
  assert_month_full_R7 : assert property (@(posedge clk) disable iff (!rst_n)
    (tick && rpt == RPT_MONTH && !field_eq[SEL_DATE]) |=> !irq);

endmodule

// File: tb/bcd_alarm_cmp_tb_top.sv
module bcd_alarm_cmp_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_sel = '0;
  logic [7:0] wr_data = '0;
  logic       tick = 1'b0;
  logic [7:0] cur_sec = '0, cur_min = '0, cur_hour = '0, cur_date = '0;
  logic       irq;

  int    n_chk = 0;
  int    n_err = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  bcd_alarm_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .tick(tick), .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour),
    .cur_date(cur_date), .irq(irq)
  );

  // reference model: plain integers
  int m_reg[4];
  bit m_irq = 1'b0;

  function automatic bit m_valid(int sel, int v);
    int x, t, o;
    x = (sel < 2) ? v % 128 : v % 64;
    t = x / 16;
    o = x % 16;
    if (o > 9) return 0;
    if (sel < 2)  return (t * 10 + o) <= 59;
    if (sel == 2) return (t * 10 + o) <= 23;
    return (t * 10 + o) >= 1 && (t * 10 + o) <= 31;
  endfunction

  function automatic bit m_same(int sel, int a, int b);
    int m;
    m = (sel < 2) ? 128 : 64;
    return (a % m) == (b % m);
  endfunction

  function automatic bit m_hit();
    bit ds, dm, dh, dd, es, em, eh, ed;
    ds = m_reg[0] >= 128; dm = m_reg[1] >= 128;
    dh = m_reg[2] >= 128; dd = m_reg[3] >= 128;
    es = m_same(0, m_reg[0], cur_sec);  em = m_same(1, m_reg[1], cur_min);
    eh = m_same(2, m_reg[2], cur_hour); ed = m_same(3, m_reg[3], cur_date);
    if (!dd && !dh && !dm && !ds) return es && em && eh && ed;
    if (dd && !dh && !dm && !ds)  return es && em && eh;
    if (dd && dh && !dm && !ds)   return es && em;
    if (dd && dh && dm && !ds)    return es;
    return 1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) m_reg[i] = 0;
      m_irq = 0;
    end else begin
      m_irq = tick && m_hit();
      if (wr_en && m_valid(int'(wr_sel), int'(wr_data))) m_reg[wr_sel] = int'(wr_data);
    end
  end

  // compare against the model on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      n_chk++;
      if (irq !== m_irq) begin
        n_err++;
        $display("FAIL %s model: irq=%0b expected=%0b at %0t", phase, irq, m_irq, $time);
      end
    end
  end

  task automatic chk(input logic got, input logic exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: irq=%0b expected=%0b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic tick_exp(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                          input logic [7:0] d, input logic exp, input string req);
    @(negedge clk);
    phase = req;
    cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; tick = 1'b1;
    @(negedge clk);
    chk(irq, exp, req);
    tick = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(irq, 1'b0, "R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq, 1'b0, "R1");
    tick_exp(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R1");
    tick_exp(8'h01, 8'h00, 8'h00, 8'h00, 1'b0, "R1");

    // monthly repeat
    phase = "R2";
    wr(2'd0, 8'h15); wr(2'd1, 8'h42); wr(2'd2, 8'h07); wr(2'd3, 8'h23);
    tick_exp(8'h15, 8'h42, 8'h07, 8'h23, 1'b1, "R7");
    tick_exp(8'h15, 8'h42, 8'h07, 8'h24, 1'b0, "R7");
    tick_exp(8'h15, 8'h43, 8'h07, 8'h23, 1'b0, "R7");

    // no tick, no pulse; pulse lasts one cycle
    phase = "R12";
    @(negedge clk);
    cur_sec = 8'h15; cur_min = 8'h42; cur_hour = 8'h07; cur_date = 8'h23;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(irq, 1'b0, "R12");
    end
    tick_exp(8'h15, 8'h42, 8'h07, 8'h23, 1'b1, "R12");
    @(negedge clk);
    chk(irq, 1'b0, "R12");
    tick_exp(8'h95, 8'hC2, 8'h47, 8'hE3, 1'b1, "R12");

    // daily: date byte with mask bit stored whole
    phase = "R2";
    wr(2'd3, 8'h83);
    tick_exp(8'h15, 8'h42, 8'h07, 8'h11, 1'b1, "R2");
    tick_exp(8'h15, 8'h42, 8'h07, 8'h11, 1'b1, "R8");
    tick_exp(8'h15, 8'h42, 8'h08, 8'h11, 1'b0, "R8");

    // hourly
    wr(2'd2, 8'h87);
    tick_exp(8'h15, 8'h42, 8'h12, 8'h05, 1'b1, "R9");
    tick_exp(8'h15, 8'h41, 8'h12, 8'h05, 1'b0, "R9");

    // once a minute
    wr(2'd1, 8'hC2);
    tick_exp(8'h15, 8'h00, 8'h00, 8'h01, 1'b1, "R10");
    tick_exp(8'h16, 8'h00, 8'h00, 8'h01, 1'b0, "R10");

    // seconds range
    phase = "R3";
    wr(2'd0, 8'h60); wr(2'd0, 8'hDA);
    tick_exp(8'h15, 8'h00, 8'h00, 8'h01, 1'b1, "R3");
    wr(2'd0, 8'h59);
    tick_exp(8'h59, 8'h00, 8'h00, 8'h01, 1'b1, "R3");
    tick_exp(8'h15, 8'h00, 8'h00, 8'h01, 1'b0, "R3");

    // every tick
    phase = "R11";
    wr(2'd0, 8'hD9);
    tick_exp(8'h00, 8'h00, 8'h00, 8'h00, 1'b1, "R11");
    tick_exp(8'h33, 8'h12, 8'h05, 8'h09, 1'b1, "R11");
    wr(2'd3, 8'h23);
    tick_exp(8'h01, 8'h02, 8'h03, 8'h04, 1'b1, "R11");

    // hours range, daily mode
    phase = "R4";
    wr(2'd3, 8'h81); wr(2'd2, 8'h23); wr(2'd1, 8'h30); wr(2'd0, 8'h45);
    tick_exp(8'h45, 8'h30, 8'h23, 8'h09, 1'b1, "R4");
    wr(2'd2, 8'h24); wr(2'd2, 8'h1A);
    tick_exp(8'h45, 8'h30, 8'h23, 8'h09, 1'b1, "R4");
    wr(2'd2, 8'h00);
    tick_exp(8'h45, 8'h30, 8'h00, 8'h09, 1'b1, "R4");
    tick_exp(8'h45, 8'h30, 8'h23, 8'h09, 0, "R4");

    // rejected minute write keeps the minute byte
    phase = "R6";
    wr(2'd1, 8'h60); wr(2'd1, 8'h5A);
    tick_exp(8'h45, 8'h30, 8'h00, 8'h09, 1'b1, "R6");
    tick_exp(8'h45, 8'h31, 8'h00, 8'h09, 1'b0, "R6");

    // date range, monthly mode
    phase = "R5";
    wr(2'd3, 8'h31);
    tick_exp(8'h45, 8'h30, 8'h00, 8'h31, 1'b1, "R5");
    wr(2'd3, 8'h00); wr(2'd3, 8'h32);
    tick_exp(8'h45, 8'h30, 8'h00, 8'h31, 1'b1, "R5");
    wr(2'd3, 8'h01);
    tick_exp(8'h45, 8'h30, 8'h00, 8'h01, 1'b1, "R5");
    tick_exp(8'h45, 8'h30, 8'h00, 8'h31, 1'b0, "R5");

    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule